// File: doc/BRIEF.md
# Call Progress Cadence Classifier

This block watches a one-bit energy envelope that is high while a supervisory tone is on the line. It times the high (tone) and low (gap) intervals and reports which call progress signal is present: steady dial tone, busy, reorder or audible ringing. Durations are counted in 1 ms ticks. The ticks come from a fractional prescaler on the 4.194304 MHz system clock. Frequency content is not examined; only the timing pattern of the envelope is used.

The envelope also toggles during speech and during DTMF digits. A DTMF steering input therefore suspends classification while it is high. The result appears as a 3-bit class code with a one-cycle strobe each time the code changes.

The control is a three-state machine:

- **IDLE** means no interval is being timed. A rising envelope edge moves it to **ON**.
- In **ON**, a tone interval is being timed:
  - If the interval reaches the dial threshold, the class becomes dial and the machine stays in ON.
  - A falling edge after the dial threshold moves it back to IDLE with class none.
  - A falling edge before the dial threshold grades the tone interval and moves to **OFF**.
- In **OFF**, a gap is being timed:
  - A rising edge grades the whole on/off period and moves to ON.
  - A gap longer than the longest accepted gap moves to IDLE with class none.
- Steering high forces IDLE from any state.

Top module: `cpc_cadence_classifier`

## Requirements
- R1: With `rst` high at a clock edge, after that edge `class_code` is 0 (none) and `class_valid` is 0.
- R2: The envelope passes through two synchroniser flops, and intervals are timed between edges of the synchronised level. The timing unit is a tick produced by accumulating TICK_HZ each cycle modulo CLK_HZ. Successive ticks are floor or ceil of CLK_HZ/TICK_HZ cycles apart, which is 4194 or 4195 cycles by default.
- R3: An interval matches a nominal length when it lies between 4/5 and 6/5 of that length, inclusive. By default busy is 400..600 ticks for both tone and gap, reorder is 200..300 ticks for both, and ringing is 1600..2400 ticks of tone with 3200..4800 ticks of gap.
- R4: A tone interval that lasts 3000 ticks without a gap sets `class_code` to 1 (dial).
- R5: Two consecutive periods whose tone and gap both match busy set `class_code` to 2 (busy).
- R6: Two consecutive periods whose tone and gap both match reorder set `class_code` to 3 (reorder).
- R7: Two consecutive periods whose tone and gap both match ringing set `class_code` to 4 (ringing).
- R8: `class_code` becomes 7 (unknown) in two cases: a tone interval shorter than the dial threshold matches no window, or a period's gap falls outside the window of its tone's cadence.
- R9: `class_code` returns to 0 in two cases: a gap exceeds the longest ringing gap (4800 ticks), or a tone that reached the dial threshold ends.
- R10: While `dtmf_steer` is high, `class_code` does not change and any partial measurement is discarded. Timing restarts at the next rising envelope edge after steering falls.
- R11: `class_valid` is high for exactly one cycle, and only in the cycle in which `class_code` takes a new value.
- R12: `class_code` only ever takes the values 0, 1, 2, 3, 4 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 4.194304 MHz by default |
| rst | input | 1 | Synchronous reset, active high |
| env_in | input | 1 | Energy envelope, asynchronous to `clk` |
| dtmf_steer | input | 1 | High while a DTMF digit is detected |
| class_code | output | 3 | 0 none, 1 dial, 2 busy, 3 reorder, 4 ringing, 7 unknown |
| class_valid | output | 1 | One-cycle pulse when `class_code` changes |

## Verification
The envelope is driven with several patterns, and each one separates a different pair of outcomes:

- A long steady tone followed by removal tells dial from none.
- Busy and reorder cadences are applied back to back, so the two-period agreement rule is exercised across a change of cadence.
- Ringing is applied after silence.
- A tone of odd length, and a busy tone followed by a reorder gap, both drive the unknown path.
- Intervals just inside and just outside the busy window test the ±20 % edges.
- A reorder pattern is played under DTMF steering and must leave the previous class untouched.

Every cycle the class code and strobe are compared with a behavioural model that runs at a fast tick ratio, so tick alternation and synchroniser latency are checked as well.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_DIAL    = 3'd1,
        CLS_BUSY    = 3'd2,
        CLS_REORDER = 3'd3,
        CLS_RING    = 3'd4,
        CLS_UNKNOWN = 3'd7
    } cls_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } st_t;

endpackage

// File: rtl/cpc_sync_edge.sv
module cpc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[SYNC_STAGES-1];
    end

    assign level = chain[SYNC_STAGES-1];
    assign rise  = level & ~last_q;
    assign fall  = ~level & last_q;

endmodule

// File: rtl/cpc_tick_gen.sv
module cpc_tick_gen #(
    parameter int CLK_HZ  = 4194304,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign sum  = acc_q + ACC_W'(TICK_HZ);
    assign tick = (sum >= ACC_W'(CLK_HZ));

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (tick) acc_q <= sum - ACC_W'(CLK_HZ);
        else           acc_q <= sum;
    end

endmodule

// File: rtl/cpc_window.sv
module cpc_window
    import cpc_pkg::*;
#(
    parameter int W           = 13,
    parameter int BUSY_MS     = 500,
    parameter int REORDER_MS  = 250,
    parameter int RING_ON_MS  = 2000,
    parameter int RING_OFF_MS = 4000
) (
    input  logic [W-1:0] dur,
    input  logic         gap_phase,
    output cls_t         cat
);

    localparam int BUSY_LO   = BUSY_MS * 4 / 5;
    localparam int BUSY_HI   = BUSY_MS * 6 / 5;
    localparam int REORD_LO  = REORDER_MS * 4 / 5;
    localparam int REORD_HI  = REORDER_MS * 6 / 5;
    localparam int RON_LO    = RING_ON_MS * 4 / 5;
    localparam int RON_HI    = RING_ON_MS * 6 / 5;
    localparam int ROFF_LO   = RING_OFF_MS * 4 / 5;
    localparam int ROFF_HI   = RING_OFF_MS * 6 / 5;

    logic [31:0] d;
    logic        in_busy, in_reord, in_ring;

    assign d        = 32'(dur);
    assign in_busy  = (d >= 32'(BUSY_LO))  && (d <= 32'(BUSY_HI));
    assign in_reord = (d >= 32'(REORD_LO)) && (d <= 32'(REORD_HI));
    assign in_ring  = gap_phase ? ((d >= 32'(ROFF_LO)) && (d <= 32'(ROFF_HI)))
                                : ((d >= 32'(RON_LO))  && (d <= 32'(RON_HI)));

    always_comb begin
        if (in_busy)       cat = CLS_BUSY;
        else if (in_reord) cat = CLS_REORDER;
        else if (in_ring)  cat = CLS_RING;
        else               cat = CLS_NONE;
    end

endmodule

// File: rtl/cpc_cadence_classifier.sv
module cpc_cadence_classifier
    import cpc_pkg::*;
#(
    parameter int CLK_HZ      = 4194304,
    parameter int TICK_HZ     = 1000,
    parameter int BUSY_MS     = 500,
    parameter int REORDER_MS  = 250,
    parameter int RING_ON_MS  = 2000,
    parameter int RING_OFF_MS = 4000,
    parameter int DIAL_MS     = 3000,
    parameter int MATCH_NEED  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       env_in,
    input  logic       dtmf_steer,
    output logic [2:0] class_code,
    output logic       class_valid
);

    localparam int SILENCE_MS = RING_OFF_MS * 6 / 5 + 1;
    localparam int RUN_MAX    = (SILENCE_MS > DIAL_MS) ? SILENCE_MS : DIAL_MS;
    localparam int RUN_W      = $clog2(RUN_MAX + 1);
    localparam int CNT_W      = $clog2(MATCH_NEED + 1);

    logic             env_lvl, env_rise, env_fall;
    logic             tick;
    logic [RUN_W-1:0] run_q;
    cls_t             cat_now;

    st_t              state_q, state_n;
    cls_t             oncat_q, oncat_n;
    cls_t             last_q, last_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    cls_t             cls_q, cls_n;
    logic             valid_q;

    cpc_sync_edge #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (env_in),
        .level    (env_lvl),
        .rise     (env_rise),
        .fall     (env_fall)
    );

    cpc_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cpc_window #(
        .W           (RUN_W),
        .BUSY_MS     (BUSY_MS),
        .REORDER_MS  (REORDER_MS),
        .RING_ON_MS  (RING_ON_MS),
        .RING_OFF_MS (RING_OFF_MS)
    ) u_win (
        .dur       (run_q),
        .gap_phase (state_q == ST_OFF),
        .cat       (cat_now)
    );

    // interval timer in ticks, restarted at each synchronised edge
    always_ff @(posedge clk) begin
        if (rst)                                    run_q <= '0;
        else if (env_rise || env_fall)              run_q <= '0;
        else if (tick && run_q != RUN_W'(RUN_MAX))  run_q <= run_q + 1'b1;
    end

    always_comb begin
        state_n = state_q;
        oncat_n = oncat_q;
        last_n  = last_q;
        cnt_n   = cnt_q;
        cls_n   = cls_q;
        if (dtmf_steer) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            last_n  = CLS_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (env_rise) state_n = ST_ON;
                end
                ST_ON: begin
                    if (env_fall) begin
                        if (run_q >= RUN_W'(DIAL_MS)) begin
                            state_n = ST_IDLE;
                            cls_n   = CLS_NONE;
                            cnt_n   = '0;
                            last_n  = CLS_NONE;
                        end else begin
                            state_n = ST_OFF;
                            oncat_n = cat_now;
                            if (cat_now == CLS_NONE) begin
                                cls_n  = CLS_UNKNOWN;
                                cnt_n  = '0;
                                last_n = CLS_NONE;
                            end
                        end
                    end else if (run_q >= RUN_W'(DIAL_MS)) begin
                        cls_n = CLS_DIAL;
                    end
                end
                ST_OFF: begin
                    if (env_rise) begin
                        state_n = ST_ON;
                        if (oncat_q != CLS_NONE && cat_now == oncat_q) begin
                            if (oncat_q == last_q) begin
                                if (cnt_q != CNT_W'(MATCH_NEED)) cnt_n = cnt_q + 1'b1;
                            end else begin
                                last_n = oncat_q;
                                cnt_n  = CNT_W'(1);
                            end
                            if (cnt_n == CNT_W'(MATCH_NEED)) cls_n = oncat_q;
                        end else begin
                            cls_n  = CLS_UNKNOWN;
                            cnt_n  = '0;
                            last_n = CLS_NONE;
                        end
                    end else if (run_q >= RUN_W'(SILENCE_MS)) begin
                        state_n = ST_IDLE;
                        cls_n   = CLS_NONE;
                        cnt_n   = '0;
                        last_n  = CLS_NONE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            oncat_q <= CLS_NONE;
            last_q  <= CLS_NONE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            oncat_q <= oncat_n;
            last_q  <= last_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q   <= CLS_NONE;
            valid_q <= 1'b0;
        end else begin
            cls_q   <= cls_n;
            valid_q <= (cls_n != cls_q);
        end
    end

    assign class_code  = cls_q;
    assign class_valid = valid_q;

endmodule

// File: rtl/cpc_cadence_checker.sv
module cpc_cadence_checker #(
    parameter int CLK_HZ  = 4194304,
    parameter int TICK_HZ = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       dtmf_steer,
    input logic [2:0] class_code,
    input logic       class_valid,
    input logic       tick
);

    localparam int MAX_GAP = (CLK_HZ + TICK_HZ - 1) / TICK_HZ;

    int gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick)         gap_q <= 0;
        else if (gap_q < MAX_GAP) gap_q <= gap_q + 1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (class_code == 3'd0 && !class_valid)); // R1

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        gap_q < MAX_GAP); // R2

    AST_STEER_FREEZES: assert property (@(posedge clk) disable iff (rst)
        dtmf_steer |=> $stable(class_code)); // R10

    AST_VALID_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        class_valid |-> (class_code != $past(class_code))); // R11

    AST_CHANGE_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        (class_code != $past(class_code)) |-> class_valid); // R11

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        class_code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7}); // R12

endmodule

bind cpc_cadence_classifier cpc_cadence_checker #(
    .CLK_HZ  (CLK_HZ),
    .TICK_HZ (TICK_HZ)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dtmf_steer  (dtmf_steer),
    .class_code  (class_code),
    .class_valid (class_valid),
    .tick        (tick)
);

// File: tb/cpc_cadence_classifier_tb.sv
`timescale 1ns/1ps
module cpc_cadence_classifier_tb;

    localparam int CLK_HZ  = 3;
    localparam int TICK_HZ = 2;
    localparam int DIAL    = 3000;
    localparam int SIL     = 4801;
    localparam int WD_LIM  = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       env = 1'b0;
    logic       steer = 1'b0;
    logic [2:0] class_code;
    logic       class_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpc_cadence_classifier #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .env_in      (env),
        .dtmf_steer  (steer),
        .class_code  (class_code),
        .class_valid (class_valid)
    );

    // behavioural reference: 0 idle, 1 tone, 2 gap
    int m_acc, m_s1, m_s2, m_s3, m_st, m_run, m_on, m_last, m_cnt, m_cls, m_val;

    function automatic int grade(int d, bit gap);
        if (d >= 400 && d <= 600) return 2;
        if (d >= 200 && d <= 300) return 3;
        if (!gap && d >= 1600 && d <= 2400) return 4;
        if (gap && d >= 3200 && d <= 4800) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0; m_run = 0;
            m_on = 0; m_last = 0; m_cnt = 0; m_cls = 0; m_val = 0;
        end else begin
            int nc;
            bit up, dn, tk;
            int g;
            up = (m_s2 == 1 && m_s3 == 0);
            dn = (m_s2 == 0 && m_s3 == 1);
            tk = (m_acc + TICK_HZ >= CLK_HZ);   // R2 fractional tick
            g  = grade(m_run, m_st == 2);
            nc = m_cls;
            if (steer) begin                    // R10
                m_st = 0; m_cnt = 0; m_last = 0;
            end else if (m_st == 0) begin
                if (up) m_st = 1;
            end else if (m_st == 1) begin
                if (dn && m_run >= DIAL) begin
                    m_st = 0; nc = 0; m_cnt = 0; m_last = 0;
                end else if (dn) begin
                    m_st = 2; m_on = g;
                    if (g == 0) begin nc = 7; m_cnt = 0; m_last = 0; end
                end else if (m_run >= DIAL) nc = 1;
            end else begin
                if (up) begin
                    m_st = 1;
                    if (m_on != 0 && g == m_on) begin
                        if (m_on == m_last) begin
                            if (m_cnt < 2) m_cnt++;
                        end else begin
                            m_last = m_on; m_cnt = 1;
                        end
                        if (m_cnt == 2) nc = m_on;
                    end else begin
                        nc = 7; m_cnt = 0; m_last = 0;
                    end
                end else if (m_run >= SIL) begin
                    m_st = 0; nc = 0; m_cnt = 0; m_last = 0;
                end
            end
            if (up || dn) m_run = 0;
            else if (tk && m_run < SIL) m_run++;
            m_acc = tk ? m_acc + TICK_HZ - CLK_HZ : m_acc + TICK_HZ;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(env);
            m_val = (nc != m_cls) ? 1 : 0;
            m_cls = nc;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            n_cmp++;
            if (int'(class_code) != m_cls || int'(class_valid) != m_val) begin
                n_bad++;
                $display("FAIL R2/R11 cycle %0d: code=%0d valid=%0d expected code=%0d valid=%0d",
                         cyc, class_code, class_valid, m_cls, m_val);
            end
        end
        if (cyc >= WD_LIM && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected finish before %0d", cyc, WD_LIM);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic phase(input logic lvl, input int ms);
        env = lvl;
        repeat (ms * 3 / 2) @(negedge clk);
    endtask

    task automatic expect_cls(input int exp, input string req);
        n_cmp++;
        if (int'(class_code) != exp) begin
            n_bad++;
            $display("FAIL %s: class_code=%0d expected %0d", req, class_code, exp);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        n_cmp++;
        if (class_code !== 3'd0 || class_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: code=%0d valid=%0d expected 0/0", class_code, class_valid);
        end
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // steady tone, then removal
        phase(1, 3200); expect_cls(1, "R4 dial");
        phase(0, 50);   expect_cls(0, "R9 dial ended");

        // busy cadence
        phase(1, 500); phase(0, 500); phase(1, 500); phase(0, 500);
        phase(1, 20);  expect_cls(2, "R5 busy");
        phase(1, 480); phase(0, 500);

        // switch straight to reorder
        phase(1, 250); phase(0, 250); phase(1, 250); phase(0, 250);
        phase(1, 20);  expect_cls(3, "R6 reorder");
        phase(1, 230); phase(0, 5000); expect_cls(0, "R9 silence");

        // ringing
        phase(1, 2000); phase(0, 4000); phase(1, 2000); phase(0, 4000);
        phase(1, 20);   expect_cls(4, "R7 ringing");
        phase(1, 1980); phase(0, 5000); expect_cls(0, "R9 silence after ring");

        // tone matching nothing
        phase(1, 1000); phase(0, 20); expect_cls(7, "R8 odd tone");
        phase(0, 5000); expect_cls(0, "R9 silence after unknown");

        // busy tone with reorder gap
        phase(1, 500); phase(0, 250); phase(1, 20); expect_cls(7, "R8 mixed period");
        phase(1, 480); phase(0, 5000); expect_cls(0, "R9 silence after mix");

        // window edges
        phase(1, 590); phase(0, 410); phase(1, 590); phase(0, 410);
        phase(1, 20);  expect_cls(2, "R3 inside window");
        phase(1, 570); phase(0, 660); phase(1, 20); expect_cls(7, "R3 outside window");
        phase(1, 480); phase(0, 500); phase(1, 500); phase(0, 500);
        phase(1, 20);  expect_cls(2, "R5 busy again");

        // steering suppresses classification
        steer = 1'b1;
        phase(1, 230); phase(0, 250); phase(1, 250); phase(0, 250);
        phase(1, 250); phase(0, 250); phase(1, 250); phase(0, 250);
        expect_cls(2, "R10 held under steering");
        steer = 1'b0;
        phase(0, 20);
        phase(1, 250); phase(0, 250); phase(1, 250); phase(0, 250);
        phase(1, 20);  expect_cls(3, "R10 resumes after steering");
        phase(1, 230); phase(0, 5000); expect_cls(0, "R9 final silence");

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule